// File: doc/BRIEF.md
# Pad Function Routing Multiplexer

This block sits between a bank of 30 chip pads and ten on-chip peripheral functions. Every pad holds a small configuration word. A 4-bit selector in that word chooses which peripheral drives the pad's output value and output enable. The same selector chooses which peripheral input receives the pad's level. Three 2-bit override fields can then reshape the chosen output, the chosen output enable and the incoming pad level: pass the signal through, invert it, force it low or force it high.

Each peripheral function offers a set of lanes, eight by default. Pad `p` always connects to lane `p mod LANES` of whichever function it selects. Several pads can therefore feed the same peripheral input lane. When they do, that lane receives the logical OR of their contributions. Selector codes 0 to 9 name real functions: memory interface, SPI, UART, I2C, PWM, software-controlled IO, programmable IO 0, programmable IO 1, clock and USB. Code 0xF selects nothing.

Configuration uses a plain port. One write is accepted per clock and lands on the next rising edge. Readback is combinational and indexed by pad number. The routing from the stored configuration to the pads and peripheral inputs is purely combinational. No pin carries streaming data, so the block has no valid/ready handshake and no back-pressure.

Top module: `pinmux_top`

## Requirements
- R1: After reset every pad's configuration word reads 0x00F: selector null and all overrides pass-through. With this configuration `pad_out`, `pad_oe` and `fn_in` are all zero, whatever is driven on the inputs.
- R2: A write presents `cfg_we`=1 and a pad index on `cfg_addr`. The word on `cfg_wdata` is laid out as selector [3:0], output override [5:4], output-enable override [7:6] and input override [9:8]. The word is stored on the next rising clock edge and has no effect before that edge. `cfg_rdata` shows the stored word for the pad on `cfg_raddr` in the same cycle.
- R3: A write with `cfg_addr` of 30 or more changes no stored word and no routed signal. A read of such an index returns 0.
- R4: A pad with selector f in 0..9 takes `pad_out` from `fn_out[f*8 + p%8]` and `pad_oe` from `fn_oe[f*8 + p%8]` before overrides. Here p is the pad index.
- R5: A pad with selector 10..15 (0xF being null) has pre-override output and output enable of 0. It contributes 0 to every peripheral input.
- R6: Bit `fn_in[f*8 + l]` is the OR of the post-override input of every pad p with selector f and p%8 == l. A pad feeds only the function it selects.
- R7: The output override code acts on the pre-override output: 0 passes it, 1 inverts it, 2 forces 0 and 3 forces 1. This holds for a null selector as well.
- R8: The output-enable override uses the same codes on the pre-override output enable.
- R9: The input override uses the same codes on the pad's `pad_in` level before it is ORed into `fn_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Pad index for the write |
| cfg_wdata | input | 10 | Configuration word to write |
| cfg_raddr | input | 5 | Pad index for readback |
| cfg_rdata | output | 10 | Stored configuration word of the read pad |
| pad_in | input | 30 | Level seen at each pad |
| fn_out | input | 80 | Output value from each function lane (function-major) |
| fn_oe | input | 80 | Output enable from each function lane (function-major) |
| pad_out | output | 30 | Output value driven to each pad |
| pad_oe | output | 30 | Output enable driven to each pad |
| fn_in | output | 80 | Input delivered to each function lane (function-major) |

## Verification
Several properties are checked on every cycle:
- A write to a valid pad lands on the next edge, and a write to an index of 30 or more leaves all stored words unchanged.
- A force-low or force-high override always wins on `pad_out` and `pad_oe`.
- A null or unimplemented selector with pass-through gives zero output and output enable.
- No peripheral lane sees a 1 while no pad holds a valid selector.

Other behaviour depends on data patterns and can only be shown by the bench's scenarios:
- lane routing from `fn_out` and `fn_oe` under several data patterns;
- the OR of pads that share a function lane;
- inversion on each path;
- the input override feeding into the OR;
- the absence of any effect before the write edge.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  localparam int SEL_W = 4;
  localparam int OVR_W = 2;

  // Function selector codes; codes 10..14 are unimplemented.
  typedef enum logic [SEL_W-1:0] {
    FN_MEMIF = 4'd0,
    FN_SPI   = 4'd1,
    FN_UART  = 4'd2,
    FN_I2C   = 4'd3,
    FN_PWM   = 4'd4,
    FN_SWIO  = 4'd5,
    FN_PROG0 = 4'd6,
    FN_PROG1 = 4'd7,
    FN_CLK   = 4'd8,
    FN_USB   = 4'd9,
    FN_NONE  = 4'hF
  } func_sel_e;

  typedef enum logic [OVR_W-1:0] {
    OVR_PASS = 2'd0,
    OVR_INV  = 2'd1,
    OVR_LOW  = 2'd2,
    OVR_HIGH = 2'd3
  } ovr_e;

  // Packed MSB-first: input override [9:8], oe [7:6], out [5:4], sel [3:0].
  typedef struct packed {
    logic [OVR_W-1:0] in_ovr;
    logic [OVR_W-1:0] oe_ovr;
    logic [OVR_W-1:0] out_ovr;
    logic [SEL_W-1:0] sel;
  } pad_cfg_t;

  localparam int CFG_W = $bits(pad_cfg_t);

  localparam pad_cfg_t CFG_RESET = '{
    in_ovr:  OVR_PASS,
    oe_ovr:  OVR_PASS,
    out_ovr: OVR_PASS,
    sel:     FN_NONE
  };

  function automatic logic apply_ovr(input logic [OVR_W-1:0] mode, input logic val);
    unique case (mode)
      2'd0:    return val;
      2'd1:    return ~val;
      2'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/pinmux_cfg_regs.sv
module pinmux_cfg_regs
  import pinmux_pkg::*;
#(
  parameter int NUM_PADS = 30,
  parameter int ADDR_W   = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            waddr,
  input  pad_cfg_t                     wdata,
  input  logic [ADDR_W-1:0]            raddr,
  output pad_cfg_t                     rdata,
  output pad_cfg_t [NUM_PADS-1:0]      cfg_q
);

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_reg
    logic hit;
    assign hit = we && (waddr == ADDR_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[p] <= CFG_RESET;
      end else if (hit) begin
        cfg_q[p] <= wdata;
      end
    end
  end

  // Out-of-range indices read as zero.
  always_comb begin
    rdata = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (raddr == ADDR_W'(p)) rdata = cfg_q[p];
    end
  end

endmodule

// File: rtl/pinmux_pad_route.sv
module pinmux_pad_route
  import pinmux_pkg::*;
#(
  parameter int NUM_FUNCS = 10
) (
  input  pad_cfg_t               cfg,
  input  logic [NUM_FUNCS-1:0]   lane_out,
  input  logic [NUM_FUNCS-1:0]   lane_oe,
  input  logic                   pad_in,
  output logic                   pad_out,
  output logic                   pad_oe,
  output logic [NUM_FUNCS-1:0]   in_contrib
);

  logic [NUM_FUNCS-1:0] fn_hit;
  logic                 raw_out;
  logic                 raw_oe;
  logic                 in_eff;

  // One-hot decode; unimplemented and null codes give an all-zero vector.
  for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_dec
    assign fn_hit[f] = (cfg.sel == SEL_W'(f));
  end

  assign raw_out = |(fn_hit & lane_out);
  assign raw_oe  = |(fn_hit & lane_oe);

  assign pad_out = apply_ovr(cfg.out_ovr, raw_out);
  assign pad_oe  = apply_ovr(cfg.oe_ovr, raw_oe);

  assign in_eff     = apply_ovr(cfg.in_ovr, pad_in);
  assign in_contrib = fn_hit & {NUM_FUNCS{in_eff}};

endmodule

// File: rtl/pinmux_in_combine.sv
module pinmux_in_combine #(
  parameter int NUM_PADS  = 30,
  parameter int NUM_FUNCS = 10,
  parameter int LANES     = 8
) (
  input  logic [NUM_PADS*NUM_FUNCS-1:0] contrib,
  output logic [NUM_FUNCS*LANES-1:0]    fn_in
);

  always_comb begin
    fn_in = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      for (int f = 0; f < NUM_FUNCS; f++) begin
        fn_in[f*LANES + (p % LANES)] = fn_in[f*LANES + (p % LANES)]
                                       | contrib[p*NUM_FUNCS + f];
      end
    end
  end

endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
  import pinmux_pkg::*;
#(
  parameter  int NUM_PADS  = 30,
  parameter  int NUM_FUNCS = 10,
  parameter  int LANES     = 8,
  localparam int ADDR_W    = $clog2(NUM_PADS),
  localparam int LANE_TOT  = NUM_FUNCS * LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic [ADDR_W-1:0]    cfg_raddr,
  output logic [CFG_W-1:0]     cfg_rdata,
  input  logic [NUM_PADS-1:0]  pad_in,
  input  logic [LANE_TOT-1:0]  fn_out,
  input  logic [LANE_TOT-1:0]  fn_oe,
  output logic [NUM_PADS-1:0]  pad_out,
  output logic [NUM_PADS-1:0]  pad_oe,
  output logic [LANE_TOT-1:0]  fn_in
);

  pad_cfg_t [NUM_PADS-1:0]         cfg_q;
  pad_cfg_t                        rd_word;
  logic [NUM_PADS*CFG_W-1:0]       cfg_flat;
  logic [NUM_PADS*NUM_FUNCS-1:0]   contrib;

  pinmux_cfg_regs #(
    .NUM_PADS (NUM_PADS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (pad_cfg_t'(cfg_wdata)),
    .raddr (cfg_raddr),
    .rdata (rd_word),
    .cfg_q (cfg_q)
  );

  assign cfg_rdata = rd_word;
  assign cfg_flat  = cfg_q;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int LANE = p % LANES;
    logic [NUM_FUNCS-1:0] lo;
    logic [NUM_FUNCS-1:0] le;

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_lane
      assign lo[f] = fn_out[f*LANES + LANE];
      assign le[f] = fn_oe[f*LANES + LANE];
    end

    pinmux_pad_route #(
      .NUM_FUNCS (NUM_FUNCS)
    ) u_route (
      .cfg        (cfg_q[p]),
      .lane_out   (lo),
      .lane_oe    (le),
      .pad_in     (pad_in[p]),
      .pad_out    (pad_out[p]),
      .pad_oe     (pad_oe[p]),
      .in_contrib (contrib[p*NUM_FUNCS +: NUM_FUNCS])
    );
  end

  pinmux_in_combine #(
    .NUM_PADS  (NUM_PADS),
    .NUM_FUNCS (NUM_FUNCS),
    .LANES     (LANES)
  ) u_comb (
    .contrib (contrib),
    .fn_in   (fn_in)
  );

endmodule

// File: rtl/pinmux_top_chk.sv
module pinmux_top_chk #(
  parameter int NUM_PADS  = 30,
  parameter int NUM_FUNCS = 10,
  parameter int LANES     = 8,
  parameter int ADDR_W    = 5,
  parameter int CFG_W     = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_we,
  input logic [ADDR_W-1:0]          cfg_addr,
  input logic [CFG_W-1:0]           cfg_wdata,
  input logic [NUM_PADS*CFG_W-1:0]  cfg_flat,
  input logic [NUM_PADS-1:0]        pad_out,
  input logic [NUM_PADS-1:0]        pad_oe,
  input logic [NUM_FUNCS*LANES-1:0] fn_in
);

  logic any_valid;
  always_comb begin
    any_valid = 1'b0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (int'(cfg_flat[p*CFG_W +: 4]) < NUM_FUNCS) any_valid = 1'b1;
    end
  end

  // R3
  oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (int'(cfg_addr) >= NUM_PADS)) |=> $stable(cfg_flat));

  // R6
  no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_valid |-> (fn_in == '0));

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_chk
    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_addr == ADDR_W'(p))) |=>
        (cfg_flat[p*CFG_W +: CFG_W] == $past(cfg_wdata)));

    // R7
    out_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_flat[p*CFG_W+5]) |-> (pad_out[p] == cfg_flat[p*CFG_W+4]));

    // R8
    oe_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_flat[p*CFG_W+7]) |-> (pad_oe[p] == cfg_flat[p*CFG_W+6]));

    // R5
    null_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'(cfg_flat[p*CFG_W +: 4]) >= NUM_FUNCS) &&
       (cfg_flat[p*CFG_W+4 +: 4] == 4'b0000)) |-> (!pad_out[p] && !pad_oe[p]));
  end

endmodule

bind pinmux_top pinmux_top_chk #(
  .NUM_PADS  (NUM_PADS),
  .NUM_FUNCS (NUM_FUNCS),
  .LANES     (LANES),
  .ADDR_W    (ADDR_W),
  .CFG_W     (pinmux_pkg::CFG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_flat  (cfg_flat),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .fn_in     (fn_in)
);

// File: tb/pinmux_top_bench.sv
`timescale 1ns/1ps
module pinmux_top_bench;

  localparam int NP = 30;
  localparam int NF = 10;
  localparam int NL = 8;
  localparam int LT = NF * NL;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [4:0]    cfg_addr;
  logic [9:0]    cfg_wdata;
  logic [4:0]    cfg_raddr;
  logic [9:0]    cfg_rdata;
  logic [NP-1:0] pad_in;
  logic [LT-1:0] fn_out;
  logic [LT-1:0] fn_oe;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [LT-1:0] fn_in;

  always #2 clk = ~clk;

  pinmux_top u_pinmux_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_raddr (cfg_raddr),
    .cfg_rdata (cfg_rdata),
    .pad_in    (pad_in),
    .fn_out    (fn_out),
    .fn_oe     (fn_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .fn_in     (fn_in)
  );

  typedef struct {
    int            kind;
    string         tag;
    logic [NP-1:0] eo;
    logic [NP-1:0] ee;
    logic [LT-1:0] ei;
    logic [9:0]    er;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     sb_ev;
  int       n_checks = 0;
  int       n_fails  = 0;
  bit       done     = 0;
  logic [9:0] shd [NP];

  function automatic logic ovr_bit(input logic [1:0] m, input logic v);
    case (m)
      2'd0: return v;
      2'd1: return ~v;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [LT-1:0] act, input logic [LT-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares against the design.
  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (it.kind == 0) begin
          cmp({it.tag, " pad_out"}, LT'(pad_out), LT'(it.eo));
          cmp({it.tag, " pad_oe"},  LT'(pad_oe),  LT'(it.ee));
          cmp({it.tag, " fn_in"},   fn_in,        it.ei);
        end else begin
          cmp({it.tag, " readback"}, LT'(cfg_rdata), LT'(it.er));
        end
      end
    end
  end

  task automatic chk_route(input string tag);
    sb_item_t it;
    #1;
    it.kind = 0; it.tag = tag; it.er = '0;
    it.eo = '0; it.ee = '0; it.ei = '0;
    for (int p = 0; p < NP; p++) begin
      int  s;
      int  l;
      logic ro, re;
      s  = int'(shd[p][3:0]);
      l  = p % NL;
      ro = (s < NF) ? fn_out[s*NL + l] : 1'b0;
      re = (s < NF) ? fn_oe[s*NL + l]  : 1'b0;
      it.eo[p] = ovr_bit(shd[p][5:4], ro);
      it.ee[p] = ovr_bit(shd[p][7:6], re);
      if (s < NF) it.ei[s*NL + l] = it.ei[s*NL + l] | ovr_bit(shd[p][9:8], pad_in[p]);
    end
    sb_q.push_back(it);
    -> sb_ev;
    #1;
  endtask

  task automatic chk_rd(input int addr, input string tag);
    sb_item_t it;
    cfg_raddr = 5'(addr);
    #1;
    it.kind = 1; it.tag = tag;
    it.eo = '0; it.ee = '0; it.ei = '0;
    it.er = (addr < NP) ? shd[addr] : 10'h000;
    sb_q.push_back(it);
    -> sb_ev;
    #1;
  endtask

  task automatic wr(input int addr, input logic [9:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = data;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    if (addr < NP) shd[addr] = data;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; cfg_raddr = '0;
    pad_in = '1; fn_out = '1; fn_oe = '1;
    for (int p = 0; p < NP; p++) shd[p] = 10'h00F;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset words and quiet routing with all inputs high
    for (int p = 0; p < NP; p++) chk_rd(p, "R1");
    chk_route("R1 reset routing");

    // R2: no effect before the edge, effect after it, readback
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'd3; cfg_wdata = 10'h002;
    chk_route("R2 before edge");
    @(posedge clk);
    #1;
    cfg_we = 1'b0; shd[3] = 10'h002;
    chk_route("R2 after edge");
    chk_rd(3, "R2");

    // R4: every pad on a function, several data patterns
    for (int p = 0; p < NP; p++) wr(p, 10'(p % NF));
    fn_out = {20{4'hA}}; fn_oe = {20{4'h5}}; pad_in = 30'h2AAA_AAAA;
    chk_route("R4 pattern a");
    fn_out = {10{8'h3C}}; fn_oe = {10{8'hC3}}; pad_in = 30'h1555_5555;
    chk_route("R4 pattern b");
    fn_out = {16'h0F0F, 64'h1234_5678_9ABC_DEF0}; fn_oe = ~fn_out; pad_in = 30'h3FFF_0000;
    chk_route("R4 pattern c");

    // R6: pads 1, 9, 17, 25 share lane 1 of function 3
    wr(1, 10'h003); wr(9, 10'h003); wr(17, 10'h003); wr(25, 10'h003);
    pad_in = 30'h0;
    chk_route("R6 none high");
    pad_in = 30'h1 << 9;
    chk_route("R6 one high");
    pad_in = (30'h1 << 1) | (30'h1 << 25);
    chk_route("R6 two high");

    // R5: unimplemented codes stay quiet
    fn_out = '1; fn_oe = '1; pad_in = '1;
    wr(5, 10'h00C); wr(6, 10'h00E); wr(7, 10'h00A);
    chk_route("R5 unimplemented");

    // R7: output override codes, with both source values
    for (int m = 0; m < 4; m++) begin
      wr(3, {2'b00, 2'b00, 2'(m), 4'h2});
      fn_out = '0; chk_route("R7 src0");
      fn_out = '1; chk_route("R7 src1");
    end
    wr(12, {2'b00, 2'b00, 2'd3, 4'hF});
    chk_route("R7 null forced high");

    // R8: output enable override codes
    for (int m = 0; m < 4; m++) begin
      wr(4, {2'b00, 2'(m), 2'b00, 4'h1});
      fn_oe = '0; chk_route("R8 src0");
      fn_oe = '1; chk_route("R8 src1");
    end

    // R9: input override codes feeding the OR
    for (int m = 0; m < 4; m++) begin
      wr(9, {2'(m), 2'b00, 2'b00, 4'h3});
      pad_in = 30'h0;     chk_route("R9 pad low");
      pad_in = 30'h1 << 9; chk_route("R9 pad high");
    end

    // R3: writes beyond the last pad change nothing
    wr(30, 10'h3FF);
    wr(31, 10'h155);
    for (int p = 0; p < NP; p++) chk_rd(p, "R3 words");
    chk_rd(30, "R3 read oob");
    chk_route("R3 routing");

    done = 1;
    summary();
    $finish;
  end

endmodule